// File: doc/BRIEF.md
# Per-Processor Countdown Timer

This block is the countdown timer of a processor's local interrupt controller. Software programs three registers through a small synchronous write port. The first is a timer vector entry that holds the interrupt vector, a mask bit and a periodic-mode bit. The second is an initial count. The third is a divide setting that picks a power-of-two prescale of the clock. Writing the initial count marks the load point. From then on the block counts ticks, where each tick lasts 2^shift clock cycles. It raises an interrupt once or repeatedly, depending on the mode.

The interrupt comes out as a one-cycle pulse, and the programmed vector is presented next to it. The live current count is available both as an output and at a read address. Prioritisation and acknowledgement of interrupts are handled elsewhere.

Top module: `cpu_local_timer`

## Requirements
- R1: After reset the vector entry reads 0x0001_0000 (masked, one-shot, vector 0), the initial count and the divide setting read 0, the current count is 0 and no pulse is raised.
- R2: The divide setting uses write-data bits 3, 1 and 0 as a 3-bit value v = {bit3, bit1, bit0}. The tick shift is (v+1) mod 8, so v=0 divides by 2, v=6 divides by 128 and v=7 divides by 1.
- R3: In one-shot mode (entry bit 17 clear) with an initial count N > 0 and the entry unmasked, exactly one pulse occurs. It is raised in the cycle after the ((N+1) << shift)-th rising edge that follows the load edge.
- R4: In periodic mode (entry bit 17 set) with N > 0 and the entry unmasked, a pulse occurs after every ((N+1) << shift) edges counted from the load edge.
- R5: An initial count of 0 produces no pulse in either mode. Writing 0 while the timer is running stops it at once and the current count reads 0.
- R6: While the mask bit (entry bit 16) is set, no pulse is raised but counting goes on. A one-shot expiry that passes while masked is lost and is not raised after unmasking.
- R7: In one-shot mode the current count is N minus the elapsed ticks, held at 0 once the ticks reach N.
- R8: In periodic mode the current count is N minus (elapsed ticks mod (N+1)).
- R9: Writing the initial count restarts the timer from that write edge and discards the earlier progress.
- R10: A pulse lasts exactly one cycle. The vector output carries bits 7:0 of the entry.
- R11: Register addresses are: 0 for the vector entry (fields at bits 7:0, 16 and 17), 1 for the initial count, 2 for the divide setting and 3 for the current count. Address 3 is read-only and a write to it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the raw time base |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 32 | Read data for rd_addr (combinational) |
| cur_count | output | CNT_W | Live current count |
| irq_pulse | output | 1 | One-cycle timer interrupt request |
| irq_vector | output | 8 | Vector of the timer entry |

## Verification
The assertions check four things on every cycle. A pulse never lasts two cycles. No pulse follows a cycle in which the entry was masked or the initial count was zero. The current count never exceeds the initial count, and it equals the initial count right after a load. Only the bench scenarios can show that pulses land on the exact edge for each divider and count, that one-shot mode fires only once, and that the count falls in the right pattern. The same holds for an expiry lost under the mask, a restart on reload and a write to the read-only address. For these the bench sweeps every divide code against small counts in both modes, with and without the mask.

// File: rtl/clt_pkg.sv
// Shared types and helpers for the per-processor countdown timer.
// Assumes a 2-bit register address space and a 3-bit tick shift.
package clt_pkg;

    typedef enum logic [1:0] {
        CLT_A_ENTRY = 2'd0,
        CLT_A_INIT  = 2'd1,
        CLT_A_DIV   = 2'd2,
        CLT_A_CUR   = 2'd3
    } clt_addr_e;

    localparam int ENTRY_MASK_BIT = 16;
    localparam int ENTRY_PER_BIT  = 17;
    localparam int SHIFT_W        = 3;

    typedef struct packed {
        logic       periodic;
        logic       masked;
        logic [7:0] vector;
    } clt_entry_t;

    // Maps the stored divide setting to a right-shift amount (7 wraps to 0).
    function automatic logic [SHIFT_W-1:0] div_to_shift(input logic [3:0] cfg);
        logic [SHIFT_W-1:0] v;
        v = {cfg[3], cfg[1:0]};
        return v + 3'd1;
    endfunction

endpackage

// File: rtl/clt_regs.sv
// Register file of the timer: vector entry, initial count, divide setting.
// Assumes DATA_W >= 18 and DATA_W >= CNT_W; writes take effect at the clock edge.
module clt_regs
    import clt_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output clt_entry_t        entry_q,
    output logic [CNT_W-1:0]  init_q,
    output logic [3:0]        div_q,
    output logic              load
);

    // Load strobe: a write to the initial count restarts the timer.
    always_comb load = wr_en && (clt_addr_e'(wr_addr) == CLT_A_INIT);

    // Register update; the current-count address is read-only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            entry_q <= '{periodic: 1'b0, masked: 1'b1, vector: 8'h00};
            init_q  <= '0;
            div_q   <= '0;
        end else if (wr_en) begin
            case (clt_addr_e'(wr_addr))
                CLT_A_ENTRY: entry_q <= '{periodic: wr_data[ENTRY_PER_BIT],
                                          masked:   wr_data[ENTRY_MASK_BIT],
                                          vector:   wr_data[7:0]};
                CLT_A_INIT:  init_q  <= wr_data[CNT_W-1:0];
                CLT_A_DIV:   div_q   <= {wr_data[3], 1'b0, wr_data[1:0]};
                default:     ;
            endcase
        end
    end

endmodule

// File: rtl/clt_tick_base.sv
// Counts raw clock cycles since the last load and derives prescaled ticks.
// Assumes the shift is held steady while a count is running.
module clt_tick_base #(
    parameter int EL_W    = 40,
    parameter int SHIFT_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [SHIFT_W-1:0] shift,
    output logic [EL_W-1:0]    tick_q,
    output logic [EL_W-1:0]    tick_nx,
    output logic               adv
);

    logic [EL_W-1:0] elapsed_q;
    logic [EL_W-1:0] elapsed_nx;

    // Next raw count: cleared by a load, saturating at all ones.
    always_comb begin
        if (load)
            elapsed_nx = '0;
        else if (&elapsed_q)
            elapsed_nx = elapsed_q;
        else
            elapsed_nx = elapsed_q + 1'b1;
    end

    // Tick view of the raw count and the tick-advance flag.
    always_comb begin
        tick_q  = elapsed_q >> shift;
        tick_nx = elapsed_nx >> shift;
        adv     = !load && (tick_nx != tick_q);
    end

    // Raw elapsed-cycle register.
    always_ff @(posedge clk) begin
        if (!rst_n) elapsed_q <= '0;
        else        elapsed_q <= elapsed_nx;
    end

endmodule

// File: rtl/clt_expiry.sv
// Decides expiries in one-shot and periodic mode and forms the current count.
// Assumes tick_nx moves by at most one tick per cycle while running.
module clt_expiry
    import clt_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int EL_W  = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] init_q,
    input  clt_entry_t       entry_q,
    input  logic [EL_W-1:0]  tick_q,
    input  logic [EL_W-1:0]  tick_nx,
    input  logic             adv,
    output logic             irq_pulse,
    output logic [CNT_W-1:0] cur_count
);

    localparam int PAD_W = EL_W - CNT_W;

    logic [EL_W-1:0]  init_ext;
    logic [CNT_W-1:0] pos_q;
    logic             armed_q;
    logic             nz;
    logic             crossed;
    logic             fire;

    // Expiry conditions for both modes.
    always_comb begin
        init_ext = {{PAD_W{1'b0}}, init_q};
        nz       = |init_q;
        crossed  = tick_nx > init_ext;
        if (entry_q.periodic)
            fire = nz && adv && (pos_q == init_q);
        else
            fire = nz && armed_q && crossed;
    end

    // Period position, one-shot arming and the registered pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q     <= '0;
            armed_q   <= 1'b0;
            irq_pulse <= 1'b0;
        end else if (load) begin
            pos_q     <= '0;
            armed_q   <= 1'b1;
            irq_pulse <= 1'b0;
        end else begin
            if (adv)
                pos_q <= (pos_q == init_q) ? '0 : pos_q + 1'b1;
            if (crossed)
                armed_q <= 1'b0;
            irq_pulse <= fire && !entry_q.masked;
        end
    end

    // Current count: remainder in periodic mode, clamped countdown in one-shot.
    always_comb begin
        if (!nz)
            cur_count = '0;
        else if (entry_q.periodic)
            cur_count = init_q - pos_q;
        else if (tick_q >= init_ext)
            cur_count = '0;
        else
            cur_count = init_q - tick_q[CNT_W-1:0];
    end

endmodule

// File: rtl/cpu_local_timer.sv
// Top of the per-processor countdown timer: registers, tick base, expiry logic.
// Assumes the clock is the raw time base and software reloads after changing the divider.
module cpu_local_timer
    import clt_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  cur_count,
    output logic              irq_pulse,
    output logic [7:0]        irq_vector
);

    localparam int EL_W = CNT_W + 8;

    clt_entry_t          entry_q;
    logic [CNT_W-1:0]    init_q;
    logic [3:0]          div_q;
    logic                load;
    logic                mask_bit;
    logic [SHIFT_W-1:0]  shift;
    logic [EL_W-1:0]     tick_q;
    logic [EL_W-1:0]     tick_nx;
    logic                adv;

    clt_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .entry_q(entry_q), .init_q(init_q),
        .div_q(div_q), .load(load)
    );

    // Shift amount and exposed mask bit.
    always_comb begin
        shift    = div_to_shift(div_q);
        mask_bit = entry_q.masked;
    end

    clt_tick_base #(.EL_W(EL_W), .SHIFT_W(SHIFT_W)) u_ticks (
        .clk(clk), .rst_n(rst_n), .load(load), .shift(shift),
        .tick_q(tick_q), .tick_nx(tick_nx), .adv(adv)
    );

    clt_expiry #(.CNT_W(CNT_W), .EL_W(EL_W)) u_exp (
        .clk(clk), .rst_n(rst_n), .load(load), .init_q(init_q),
        .entry_q(entry_q), .tick_q(tick_q), .tick_nx(tick_nx), .adv(adv),
        .irq_pulse(irq_pulse), .cur_count(cur_count)
    );

    // Vector output and read multiplexer.
    always_comb begin
        irq_vector = entry_q.vector;
        rd_data    = '0;
        case (clt_addr_e'(rd_addr))
            CLT_A_ENTRY: begin
                rd_data[7:0]           = entry_q.vector;
                rd_data[ENTRY_MASK_BIT] = entry_q.masked;
                rd_data[ENTRY_PER_BIT]  = entry_q.periodic;
            end
            CLT_A_INIT:  rd_data[CNT_W-1:0] = init_q;
            CLT_A_DIV:   rd_data[3:0]       = div_q;
            default:     rd_data[CNT_W-1:0] = cur_count;
        endcase
    end

endmodule

// File: rtl/clt_checker.sv
// Cycle-level properties of the countdown timer, bound to the top module.
// Assumes synchronous active-low reset.
module clt_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq_pulse,
    input logic [CNT_W-1:0] cur_count,
    input logic [CNT_W-1:0] init_q,
    input logic             mask_bit,
    input logic             load
);

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse); // R10

    AST_MASK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mask_bit) |-> !irq_pulse); // R6

    AST_ZERO_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(init_q) == '0) |-> !irq_pulse); // R5

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cur_count <= init_q); // R7

    AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        $past(load) |-> (cur_count == init_q)); // R9

endmodule

bind cpu_local_timer clt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_pulse(irq_pulse), .cur_count(cur_count),
    .init_q(init_q), .mask_bit(mask_bit), .load(load)
);

// File: tb/cpu_local_timer_bench.sv
// Sweep bench for the countdown timer; expected values are computed arithmetically.
module cpu_local_timer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [31:0] cur_count;
    logic        irq_pulse;
    logic [7:0]  irq_vector;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    cpu_local_timer u_cpu_local_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .cur_count(cur_count), .irq_pulse(irq_pulse), .irq_vector(irq_vector)
    );

    always #10 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            failures = failures + 1;
            $display("FAIL watchdog expired after %0d cycles, expected completion", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            failures = failures + 1;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One configuration: divide code v, count n, mode, mask; checked on every cycle.
    task automatic run_cfg(input int v, input int n, input bit per, input bit msk);
        int s;
        int plen;
        int win;
        int t;
        bit bad;
        logic [31:0] ecnt;
        bit epul;
        logic [7:0] vec;
        string tag;
        s    = (v + 1) % 8;
        plen = (n + 1) << s;
        win  = per ? 2 * plen + 3 : plen + 6;
        bad  = 1'b0;
        vec  = 8'(8'h20 + v * 8 + n);
        tag  = msk ? "R6" : (per ? "R4/R8/R2/R10" : "R3/R7/R2/R10");
        rd_addr = 2'd3;
        wr(2'd0, (32'(per) << 17) | (32'(msk) << 16) | 32'(vec));
        wr(2'd2, {28'd0, 1'(v >> 2), 1'b0, 2'(v)});
        wr(2'd1, 32'(n));
        for (int k = 1; k <= win; k++) begin
            @(posedge clk); #1;
            t = k >> s;
            if (n == 0) ecnt = 0;
            else if (per) ecnt = 32'(n - (t % (n + 1)));
            else ecnt = (t >= n) ? 32'd0 : 32'(n - t);
            epul = !msk && (n != 0) && (k % plen == 0) && (per || k == plen);
            if (!bad && (irq_pulse !== epul || cur_count !== ecnt || rd_data !== ecnt
                         || (epul && irq_vector !== vec))) begin
                bad = 1'b1;
                $display("FAIL %s v=%0d n=%0d k=%0d pulse=%0b/%0b count=%0d/%0d vec=%0h/%0h",
                         tag, v, n, k, irq_pulse, epul, cur_count, ecnt, irq_vector, vec);
            end
        end
        checks = checks + 1;
        if (bad) failures = failures + 1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        rd_addr = 2'd0; #1 chk("R1 entry", rd_data, 32'h0001_0000);
        rd_addr = 2'd1; #1 chk("R1 init", rd_data, 32'd0);
        rd_addr = 2'd2; #1 chk("R1 divide", rd_data, 32'd0);
        chk("R1 count", cur_count, 32'd0);
        chk("R1 pulse", 32'(irq_pulse), 32'd0);

        // R11: divide setting keeps bits 3,1,0 only
        wr(2'd2, 32'hFFFF_FFFF);
        rd_addr = 2'd2; #1 chk("R11 divide readback", rd_data, 32'h0000_000B);

        // R2/R3/R4/R6/R7/R8/R10: sweep
        for (int v = 0; v < 8; v++)
            for (int n = 0; n < 4; n++)
                for (int p = 0; p < 2; p++)
                    run_cfg(v, n, 1'(p), 1'b0);
        for (int v = 5; v < 8; v++) begin
            run_cfg(v, 2, 1'b1, 1'b1);
            run_cfg(v, 3, 1'b0, 1'b1);
        end

        // R5: zero written mid-run stops the timer
        wr(2'd2, 32'h0000_000B);
        wr(2'd0, 32'h0002_0044);
        wr(2'd1, 32'd3);
        @(posedge clk); #1;
        wr(2'd1, 32'd0);
        begin
            bit seen = 1'b0;
            for (int k = 0; k < 40; k++) begin
                @(posedge clk); #1;
                if (irq_pulse || cur_count != 0) seen = 1'b1;
            end
            chk("R5 stop on zero", 32'(seen), 32'd0);
        end

        // R11: write to current-count address ignored
        wr(2'd1, 32'd100);
        wr(2'd3, 32'd5);
        chk("R11 count after write to addr3", cur_count, 32'd99);
        rd_addr = 2'd1; #1 chk("R11 init unchanged", rd_data, 32'd100);

        // R9: reload restarts from the new write edge
        wr(2'd1, 32'd5);
        repeat (3) @(posedge clk); #1;
        wr(2'd1, 32'd2);
        chk("R9 count at reload", cur_count, 32'd2);
        @(posedge clk); #1 chk("R9 count k1", cur_count, 32'd1);
        chk("R9 no pulse k1", 32'(irq_pulse), 32'd0);
        @(posedge clk); #1 chk("R9 no pulse k2", 32'(irq_pulse), 32'd0);
        @(posedge clk); #1 chk("R9 pulse k3", 32'(irq_pulse), 32'd1);
        chk("R10 vector", 32'(irq_vector), 32'h44);
        @(posedge clk); #1 chk("R10 pulse one cycle", 32'(irq_pulse), 32'd0);

        // R6: one-shot expiry passed under mask is lost
        wr(2'd0, 32'h0001_0055);
        wr(2'd1, 32'd2);
        repeat (6) @(posedge clk); #1;
        wr(2'd0, 32'h0000_0055);
        begin
            bit seen = 1'b0;
            for (int k = 0; k < 20; k++) begin
                @(posedge clk); #1;
                if (irq_pulse) seen = 1'b1;
            end
            chk("R6 lost one-shot", 32'(seen), 32'd0);
        end
        rd_addr = 2'd0; #1 chk("R11 entry readback", rd_data, 32'h0000_0055);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule